// File: doc/BRIEF.md
# Single-Precision Fused Multiply-Add Unit

This block computes `a*b + c` on three binary32 operands (bit 31 sign, bits 30:23 biased exponent with bias 127, bits 22:0 fraction) and rounds once, after the addition, to nearest-even. The full 48-bit significand product is kept unrounded. It is aligned against the addend in a 64-bit working field, added or subtracted, normalised by a leading-zero count and only then rounded. The rounding position is fixed: the 1's place of both operands sits at bit 60 of the working field, and the kept result LSB at bit 37 before normalisation.

The unit is a three-stage pipeline: operand decode and multiply, then alignment and add, then normalise and round. A valid flag travels with each operation. One operation may enter every cycle. There is no back-pressure. Subnormal inputs are flushed to zero and results that would be subnormal are flushed to signed zero. Any NaN result is the canonical quiet NaN. Reset is synchronous and active high.

Top module: `fma32_unit`

## Requirements
- R1: `out_valid` equals `in_valid` from exactly three clock edges earlier, one operation is accepted per cycle, and reset forces `out_valid` low.
- R2: An input whose exponent field is 0 is treated as a zero with its own sign bit.
- R3: A NaN input (exponent 0xFF with nonzero fraction), infinity times zero, or an infinite product plus an infinite `c` of opposite sign gives 0x7FC00000.
- R4: In all other cases, an infinite product gives infinity with sign a^b. Finite `a` and `b` with an infinite `c` give `c`.
- R5: A zero product with nonzero `c` gives `c`. A zero product with zero `c` gives a zero signed a^b. A zero `c` with a nonzero product gives the product rounded once.
- R6: The result is rounded to 24 significant bits, to nearest with ties to even. A rounding carry out of 24 bits moves to the next binade.
- R7: In an effective subtraction, a negative difference gives its magnitude with the product sign inverted. An exact cancellation gives 0x00000000. One unit is borrowed when the addend lost nonzero bits in alignment.
- R8: An unbiased result exponent above 127 gives signed infinity (0x7F800000 or 0xFF800000).
- R9: An unbiased result exponent of -127 or below gives a signed zero. An exponent of -126 is returned as a normal number.
- R10: The product enters the addition unrounded, so the single final rounding decides the result, including after heavy cancellation.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operands on `a_op`, `b_op`, `c_op` are valid this cycle |
| a_op | input | 32 | Multiplicand, binary32 |
| b_op | input | 32 | Multiplier, binary32 |
| c_op | input | 32 | Addend, binary32 |
| out_valid | output | 1 | `result` holds a finished operation |
| result | output | 32 | Rounded binary32 value of a*b+c |

## Verification
The assertions take for granted that `in_valid` and the operands are fully defined (no X) whenever the block is out of reset. They also take for granted that reset is held for at least one edge before the first operation, so the stage valid flags start from zero. The stimulus changes inputs only on falling clock edges. It holds `in_valid` low through every reset interval and uses only explicit bit patterns for the operands, including the NaN, infinity and subnormal encodings.

// File: rtl/fma32_pkg.sv
package fma32_pkg;
  localparam int WORD     = 32;
  localparam int EXPW     = 8;
  localparam int FRACW    = 23;
  localparam int SIGW     = FRACW + 1;
  localparam int PRODW    = 2 * SIGW;
  localparam int FIELDW   = 64;
  localparam int PROD_LSB = 14;
  localparam int ADD_LSB  = 37;
  localparam int ONE_POS  = ADD_LSB + FRACW;
  localparam int EW       = 12;
  localparam int SHW      = 7;
  localparam int BIAS     = 127;
  localparam int EMAX     = 127;
  localparam int EMIN     = -126;
  localparam logic [WORD-1:0] QNAN = 32'h7FC0_0000;

  typedef logic signed [EW-1:0] exp_t;

  typedef struct packed {
    logic              ps;
    exp_t              pe;
    logic [FIELDW-1:0] pm;
    logic              cs;
    exp_t              ce;
    logic [FIELDW-1:0] cm;
    logic              spec;
    logic [WORD-1:0]   sval;
  } mul_stage_t;

  typedef struct packed {
    logic              sign;
    exp_t              ex;
    logic [FIELDW-1:0] mag;
    logic              sticky;
    logic              spec;
    logic [WORD-1:0]   sval;
  } sum_stage_t;

  function automatic logic is_zero(input logic [WORD-1:0] x);
    return x[WORD-2 -: EXPW] == '0;
  endfunction

  function automatic logic is_inf(input logic [WORD-1:0] x);
    return (x[WORD-2 -: EXPW] == '1) && (x[FRACW-1:0] == '0);
  endfunction

  function automatic logic is_nan(input logic [WORD-1:0] x);
    return (x[WORD-2 -: EXPW] == '1) && (x[FRACW-1:0] != '0);
  endfunction

  function automatic exp_t unbias(input logic [EXPW-1:0] e);
    return $signed({{(EW-EXPW){1'b0}}, e}) - exp_t'(BIAS);
  endfunction

  // Count of leading zeros; FIELDW for an all-zero word.
  function automatic logic [SHW-1:0] lzc(input logic [FIELDW-1:0] v);
    logic [SHW-1:0] n;
    n = SHW'(FIELDW);
    for (int i = 0; i < FIELDW; i++) begin
      if (v[i]) n = SHW'(FIELDW - 1 - i);
    end
    return n;
  endfunction

  // Right shift; an amount of FIELDW clears the word.
  function automatic logic [FIELDW-1:0] shr(input logic [FIELDW-1:0] v,
                                           input logic [SHW-1:0] sh);
    return (sh >= SHW'(FIELDW)) ? '0 : (v >> sh);
  endfunction

  // Nonzero-detect of the bits a right shift by sh throws away.
  function automatic logic lost_any(input logic [FIELDW-1:0] v,
                                    input logic [SHW-1:0] sh);
    if (sh == '0) return 1'b0;
    if (sh >= SHW'(FIELDW)) return |v;
    return |(v << (SHW'(FIELDW) - sh));
  endfunction
endpackage

// File: rtl/fma32_unpack_mul.sv
module fma32_unpack_mul
  import fma32_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            in_valid,
  input  logic [WORD-1:0] a,
  input  logic [WORD-1:0] b,
  input  logic [WORD-1:0] c,
  output logic            v1,
  output mul_stage_t      s1
);
  logic a_z, b_z, c_z, a_i, b_i, c_i, any_nan, prod_z, psign;
  logic [SIGW-1:0]  sa, sb, sc;
  logic [PRODW-1:0] prod;
  exp_t             pe_raw;
  mul_stage_t       nxt;

  always_comb begin
    a_z = is_zero(a);  b_z = is_zero(b);  c_z = is_zero(c);
    a_i = is_inf(a);   b_i = is_inf(b);   c_i = is_inf(c);
    any_nan = is_nan(a) | is_nan(b) | is_nan(c);
    prod_z  = a_z | b_z;
    psign   = a[WORD-1] ^ b[WORD-1];
    sa = a_z ? '0 : {1'b1, a[FRACW-1:0]};
    sb = b_z ? '0 : {1'b1, b[FRACW-1:0]};
    sc = c_z ? '0 : {1'b1, c[FRACW-1:0]};
    prod   = sa * sb;
    pe_raw = unbias(a[WORD-2 -: EXPW]) + unbias(b[WORD-2 -: EXPW]);

    nxt.ps = psign;
    nxt.pe = prod_z ? '0 : pe_raw;
    nxt.pm = FIELDW'(prod) << PROD_LSB;
    nxt.cs = c[WORD-1];
    // A zero addend takes the product exponent so the product is never shifted.
    nxt.ce = c_z ? nxt.pe : unbias(c[WORD-2 -: EXPW]);
    nxt.cm = FIELDW'(sc) << ADD_LSB;

    nxt.spec = 1'b1;
    nxt.sval = '0;
    if (any_nan) begin
      nxt.sval = QNAN;
    end else if (a_i | b_i) begin
      if (prod_z || (c_i && (c[WORD-1] != psign))) nxt.sval = QNAN;
      else nxt.sval = {psign, {EXPW{1'b1}}, {FRACW{1'b0}}};
    end else if (c_i) begin
      nxt.sval = c;
    end else if (prod_z) begin
      nxt.sval = c_z ? {psign, {(WORD-1){1'b0}}} : c;
    end else begin
      nxt.spec = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v1 <= 1'b0;
      s1 <= '0;
    end else begin
      v1 <= in_valid;
      s1 <= nxt;
    end
  end

  // R2: flushed inputs leave only normal significands, so every product is normalised at bit 60 or 61
  p_prod_norm_r2: assert property (@(posedge clk) disable iff (rst)
    (v1 && !s1.spec) |-> (s1.pm[PROD_LSB+PRODW-1] | s1.pm[PROD_LSB+PRODW-2]));

  // R3: a NaN on the multiplicand port is resolved as the canonical NaN one edge later
  p_spec_nan_r3: assert property (@(posedge clk) disable iff (rst)
    (in_valid && is_nan(a)) |=> (v1 && s1.spec && s1.sval == QNAN));
endmodule

// File: rtl/fma32_align_add.sv
module fma32_align_add
  import fma32_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       v1,
  input  mul_stage_t s1,
  output logic       v2,
  output sum_stage_t s2
);
  exp_t              diff, dmag;
  logic              prod_big, eff_sub, sticky_evt, borrow_evt, neg_evt;
  logic [SHW-1:0]    sh;
  logic [FIELDW-1:0] pm_al, cm_al, raw, mag;
  sum_stage_t        nxt;

  always_comb begin
    diff     = s1.pe - s1.ce;
    prod_big = diff > exp_t'(0);
    dmag     = prod_big ? diff : -diff;
    sh       = (dmag >= exp_t'(FIELDW)) ? SHW'(FIELDW) : dmag[SHW-1:0];
    pm_al    = prod_big ? s1.pm : shr(s1.pm, sh);
    cm_al    = prod_big ? shr(s1.cm, sh) : s1.cm;
    sticky_evt = lost_any(prod_big ? s1.cm : s1.pm, sh);
    eff_sub    = s1.ps ^ s1.cs;
    borrow_evt = eff_sub & sticky_evt & prod_big;
    raw = eff_sub ? (pm_al - cm_al - FIELDW'(borrow_evt)) : (pm_al + cm_al);
    neg_evt = raw[FIELDW-1];
    mag     = neg_evt ? (~raw + FIELDW'(1)) : raw;

    nxt.sign   = s1.ps ^ neg_evt;
    nxt.ex     = prod_big ? s1.pe : s1.ce;
    nxt.mag    = mag;
    nxt.sticky = sticky_evt;
    nxt.spec   = s1.spec;
    nxt.sval   = s1.sval;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v2 <= 1'b0;
      s2 <= '0;
    end else begin
      v2 <= v1;
      s2 <= nxt;
    end
  end

  // R1: the valid flag moves one stage per edge
  p_handoff_r1: assert property (@(posedge clk) disable iff (rst) v1 |=> v2);
  p_no_ghost_r1: assert property (@(posedge clk) disable iff (rst) !v1 |=> !v2);

  // R7: a negated difference is a proper magnitude
  p_mag_positive_r7: assert property (@(posedge clk) disable iff (rst)
    (v1 && !s1.spec && neg_evt) |-> !mag[FIELDW-1]);

  // R7: bits are only lost when an alignment shift actually happened
  p_sticky_side_r7: assert property (@(posedge clk) disable iff (rst)
    (v1 && sticky_evt) |-> (sh != '0));
endmodule

// File: rtl/fma32_norm_round.sv
module fma32_norm_round
  import fma32_pkg::*;
(
  input  logic            clk,
  input  logic            rst,
  input  logic            v2,
  input  sum_stage_t      s2,
  output logic            v3,
  output logic [WORD-1:0] res
);
  logic [SHW-1:0]    lz, pos;
  logic signed [8:0] adj;
  logic [1:0]        radj;
  logic [FIELDW-1:0] mn, kept, rem, half, mask;
  logic [SIGW:0]     rnd;
  logic              zero_evt, rup_evt, carry_evt;
  exp_t              ex_n, ex_f, ex_b;
  logic [SIGW-1:0]   sig_f;
  logic [WORD-1:0]   nxt;

  always_comb begin
    lz       = lzc(s2.mag);
    zero_evt = (s2.mag == '0);
    adj      = 9'sd3 - $signed({2'b00, lz});
    if (adj < 0) begin
      mn   = s2.mag << (-adj);
      radj = 2'd0;
    end else begin
      mn   = s2.mag;
      radj = adj[1:0];
    end
    ex_n = s2.ex + exp_t'(adj);
    pos  = SHW'(ADD_LSB) + SHW'(radj);
    mask = (FIELDW'(1) << pos) - FIELDW'(1);
    half = FIELDW'(1) << (pos - SHW'(1));
    kept = mn >> pos;
    rem  = (mn & mask) | FIELDW'(s2.sticky);
    rup_evt = (rem > half) || ((rem == half) && kept[0]);
    rnd  = kept[SIGW:0] + (SIGW+1)'(rup_evt);
    carry_evt = rnd[SIGW];
    sig_f = carry_evt ? rnd[SIGW:1] : rnd[SIGW-1:0];
    ex_f  = carry_evt ? (ex_n + exp_t'(1)) : ex_n;
    ex_b  = ex_f + exp_t'(BIAS);

    if (s2.spec)                     nxt = s2.sval;
    else if (zero_evt)               nxt = '0;
    else if (ex_f > exp_t'(EMAX))    nxt = {s2.sign, {EXPW{1'b1}}, {FRACW{1'b0}}};
    else if (ex_f < exp_t'(EMIN))    nxt = {s2.sign, {(WORD-1){1'b0}}};
    else                             nxt = {s2.sign, ex_b[EXPW-1:0], sig_f[FRACW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      v3  <= 1'b0;
      res <= '0;
    end else begin
      v3  <= v2;
      res <= nxt;
    end
  end

  // R6: after normalisation and rounding the hidden bit is always present
  p_norm_msb_r6: assert property (@(posedge clk) disable iff (rst)
    (v2 && !s2.spec && !zero_evt) |-> sig_f[SIGW-1]);

  // R6: a rounding carry can only come from an increment
  p_carry_from_round_r6: assert property (@(posedge clk) disable iff (rst)
    (v2 && carry_evt) |-> rup_evt);
endmodule

// File: rtl/fma32_unit.sv
module fma32_unit
  import fma32_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        in_valid,
  input  logic [31:0] a_op,
  input  logic [31:0] b_op,
  input  logic [31:0] c_op,
  output logic        out_valid,
  output logic [31:0] result
);
  logic       v1, v2;
  mul_stage_t s1;
  sum_stage_t s2;

  fma32_unpack_mul u_mul (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a(a_op), .b(b_op), .c(c_op), .v1(v1), .s1(s1)
  );

  fma32_align_add u_add (
    .clk(clk), .rst(rst), .v1(v1), .s1(s1), .v2(v2), .s2(s2)
  );

  fma32_norm_round u_rnd (
    .clk(clk), .rst(rst), .v2(v2), .s2(s2), .v3(out_valid), .res(result)
  );
endmodule

// File: tb/fma32_unit_tb.sv
`timescale 1ns/1ps
module fma32_unit_tb;
  logic        clk = 1'b0;
  logic        rst;
  logic        in_valid;
  logic [31:0] a_op, b_op, c_op;
  logic        out_valid;
  logic [31:0] result;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  fma32_unit u_dut (
    .clk(clk), .rst(rst), .in_valid(in_valid),
    .a_op(a_op), .b_op(b_op), .c_op(c_op),
    .out_valid(out_valid), .result(result)
  );

  // {a, b, c, expected, requirement number}
  localparam int NV = 31;
  localparam logic [131:0] VEC [NV] = '{
    {32'h40000000, 32'h40400000, 32'h3F800000, 32'h40E00000, 4'd10}, // R10 2*3+1
    {32'h3FC00000, 32'h3FC00000, 32'h3F800000, 32'h40500000, 4'd10}, // R10 1.5*1.5+1
    {32'h40000000, 32'h40400000, 32'hC1200000, 32'hC0800000, 4'd7},  // R7 sign flip
    {32'h40000000, 32'h40400000, 32'hBF800000, 32'h40A00000, 4'd10}, // R10
    {32'h40400000, 32'h40400000, 32'h00000000, 32'h41100000, 4'd5},  // R5 c zero
    {32'h00000000, 32'h40A00000, 32'hC0000000, 32'hC0000000, 4'd5},  // R5 product zero
    {32'h00000000, 32'h3F800000, 32'h80000000, 32'h00000000, 4'd5},  // R5 both zero
    {32'h7F800000, 32'h00000000, 32'h3F800000, 32'h7FC00000, 4'd3},  // R3 inf*0
    {32'h7FC00001, 32'h3F800000, 32'h3F800000, 32'h7FC00000, 4'd3},  // R3 NaN in
    {32'h7F800000, 32'h40000000, 32'hFF800000, 32'h7FC00000, 4'd3},  // R3 inf-inf
    {32'h7F800000, 32'hC0000000, 32'hFF800000, 32'hFF800000, 4'd4},  // R4
    {32'h3F800000, 32'h3F800000, 32'hFF800000, 32'hFF800000, 4'd4},  // R4 c inf
    {32'h7F7FFFFF, 32'h40000000, 32'h00000000, 32'h7F800000, 4'd8},  // R8
    {32'h8D800000, 32'h0D800000, 32'h00000000, 32'h80000000, 4'd9},  // R9 signed zero
    {32'h00000001, 32'h40000000, 32'h40400000, 32'h40400000, 4'd2},  // R2 subnormal a
    {32'h3F800000, 32'h3F800000, 32'h33800000, 32'h3F800000, 4'd6},  // R6 tie, even
    {32'h3F800000, 32'h3F800001, 32'h33800000, 32'h3F800002, 4'd6},  // R6 tie, odd
    {32'h3F800000, 32'h3F800000, 32'h33C00000, 32'h3F800001, 4'd6},  // R6 above half
    {32'h3F800000, 32'h3F800000, 32'hB0800000, 32'h3F800000, 4'd7},  // R7 1-2^-30
    {32'h3F800000, 32'h3F800000, 32'hAB800001, 32'h3F800000, 4'd7},  // R7 borrow
    {32'h3FC00000, 32'h40000000, 32'hC0400000, 32'h00000000, 4'd7},  // R7 cancel
    {32'h3F800800, 32'h3F800800, 32'hBF801000, 32'h33800000, 4'd10}, // R10 fused
    {32'h40000000, 32'h40000000, 32'h42C80000, 32'h42D00000, 4'd10}, // R10 c larger
    {32'h3F800000, 32'h40000000, 32'h00400000, 32'h40000000, 4'd2},  // R2 subnormal c
    {32'h7F800000, 32'h40000000, 32'h3F800000, 32'h7F800000, 4'd4},  // R4
    {32'hBF800000, 32'h40000000, 32'h3F800000, 32'hBF800000, 4'd7},  // R7
    {32'h20000000, 32'h20000000, 32'h00000000, 32'h00800000, 4'd9},  // R9 -126 normal
    {32'h20000000, 32'h1F800000, 32'h00000000, 32'h00000000, 4'd9},  // R9 -127 zero
    {32'h7F000000, 32'h3F800000, 32'h00000000, 32'h7F000000, 4'd8},  // R8 edge kept
    {32'h5F800000, 32'h5F800000, 32'h00000000, 32'h7F800000, 4'd8},  // R8 2^128
    {32'h3FFFFFFF, 32'h3F800000, 32'h33800000, 32'h40000000, 4'd6}   // R6 carry
  };

  logic [31:0] got [NV];
  int  cap_n = 0;
  bit  cap_en = 0;

  always @(negedge clk) begin
    if (cap_en && out_valid) begin
      if (cap_n < NV) got[cap_n] = result;
      cap_n++;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  task automatic drive(input logic v, input logic [31:0] a, input logic [31:0] b,
                       input logic [31:0] c);
    in_valid = v; a_op = a; b_op = b; c_op = c;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL R1 watchdog actual=%h expected=%h", 32'h0, 32'h1);
    finish_run();
  end

  initial begin
    rst = 1'b1;
    drive(1'b0, 32'h0, 32'h0, 32'h0);
    repeat (3) @(negedge clk);
    check(out_valid == 1'b0, "R1", "reset out_valid", {31'h0, out_valid}, 32'h0);
    rst = 1'b0;
    @(negedge clk);

    // R1 latency: launched at this falling edge, visible three edges later
    drive(1'b1, 32'h40000000, 32'h40400000, 32'h3F800000);
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 32'h0);
    check(out_valid == 1'b0, "R1", "latency edge1", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "latency edge2", {31'h0, out_valid}, 32'h0);
    @(negedge clk);
    check(out_valid == 1'b1, "R1", "latency edge3", {31'h0, out_valid}, 32'h1);
    check(result == 32'h40E00000, "R1", "latency result", result, 32'h40E00000);
    @(negedge clk);
    check(out_valid == 1'b0, "R1", "single pulse", {31'h0, out_valid}, 32'h0);

    // Vector table streamed back to back
    cap_en = 1;
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, VEC[i][131:100], VEC[i][99:68], VEC[i][67:36]);
      @(negedge clk);
    end
    drive(1'b0, 32'h0, 32'h0, 32'h0);
    repeat (5) @(negedge clk);
    cap_en = 0;
    check(cap_n == NV, "R1", "stream count", 32'(cap_n), 32'(NV));
    for (int i = 0; i < NV; i++) begin
      checks++;
      if (i >= cap_n || got[i] !== VEC[i][35:4]) begin
        errors++;
        $display("FAIL R%0d vector %0d actual=%h expected=%h", VEC[i][3:0], i,
                 (i < cap_n) ? got[i] : 32'hXXXXXXXX, VEC[i][35:4]);
      end
    end

    // R1: operands with in_valid low never produce a result
    drive(1'b0, 32'h40000000, 32'h40000000, 32'h40000000);
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "idle operands", {31'h0, out_valid}, 32'h0);
    end

    // R1: reset in flight drops the pending operation
    drive(1'b1, 32'h40000000, 32'h40400000, 32'h3F800000);
    @(negedge clk);
    drive(1'b0, 32'h0, 32'h0, 32'h0);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      check(out_valid == 1'b0, "R1", "reset flush", {31'h0, out_valid}, 32'h0);
    end

    finish_run();
  end
endmodule